// File: doc/BRIEF.md
# Out-of-Order Request Tag Tracker

This block stands between an engine that issues requests and the packet side of a link. Each request offered by the engine leaves the block carrying a source tag chosen by the block. It also carries the node and unit identity of the local agent, so the engine never builds either field itself. The block keeps the address and command of every outstanding request in a per-tag context table. At most `NUM_TAGS` requests (32 by default, the protocol limit) can be outstanding at once.

Responses come back on their own port, in any order, each carrying only a tag. The block uses that tag to look up the stored context. One cycle later it presents the address and command of the original request on the matched-response port, and it returns the tag to the free pool.

A response whose tag is not outstanding is reported as an orphan. No context is returned for it and no tag is released. Packet encoding, link integrity checks, flow-control credits and payload buffering belong to other blocks.

Top module: `tag_tracker`

## Requirements
- R1: After reset every tag is free, `match_valid` is 0, and `req_ready` equals `out_ready`.
- R2: `out_tag` is always the lowest-numbered free tag; the requester supplies no tag.
- R3: Every outgoing request carries `out_node` = `node_id` and `out_unit` = `unit_id`, with `out_addr`/`out_cmd` equal to `req_addr`/`req_cmd`.
- R4: `out_valid` = `req_valid` while a tag is free. A request is taken (its tag marked busy, its context stored) only at an edge where `req_valid`, `out_ready` and a free tag coincide. While `out_ready` is 0 nothing is taken and `out_tag` holds.
- R5: With all `NUM_TAGS` tags outstanding, `req_ready` and `out_valid` are 0.
- R6: A response on an outstanding tag gives, one cycle later, `match_valid`=1, `match_err`=0, `match_tag` equal to the response tag, and the address and command stored with that tag.
- R7: Responses may arrive in any order, and each returns the context of its own request.
- R8: A response on a tag that is not outstanding gives, one cycle later, `match_valid`=1, `match_err`=1, with `match_addr` and `match_cmd` zero. No tag is freed.
- R9: A tag is released at the edge that accepts its response and can be granted from the next cycle on.
- R10: A request and a response in the same cycle both take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NODE_W | Local node identity stamped on requests |
| unit_id | input | UNIT_W | Local unit identity stamped on requests |
| req_valid | input | 1 | Engine offers a request |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command code |
| out_valid | output | 1 | Tagged request offered to packet side |
| out_ready | input | 1 | Packet side can take a request |
| out_tag | output | TAG_W | Source tag assigned to the request |
| out_node | output | NODE_W | Node identity field |
| out_unit | output | UNIT_W | Unit identity field |
| out_addr | output | ADDR_W | Request address |
| out_cmd | output | CMD_W | Request command code |
| rsp_valid | input | 1 | Response arrives (always accepted) |
| rsp_tag | input | TAG_W | Tag carried by the response |
| match_valid | output | 1 | Matched-response result valid |
| match_err | output | 1 | Response tag was not outstanding |
| match_tag | output | TAG_W | Tag of the response |
| match_addr | output | ADDR_W | Address of the original request |
| match_cmd | output | CMD_W | Command of the original request |

## Verification
The request side is combinational: `out_valid`, `req_ready`, `out_tag` and the stamped identity fields are due in the same cycle the request is offered. The bench samples them one time unit after driving, well before the next rising edge. The matched-response outputs are due one edge after the response is driven, so the bench samples them just after that edge. A released tag shows on `out_tag` from the following cycle, and the bench checks it there. Every expected tag comes from a busy-tag model kept in the bench, which is updated at the same edge as the design.

// File: rtl/tag_tracker_pkg.sv
package tag_tracker_pkg;
   // Largest number of outstanding requests the link protocol allows
   localparam int unsigned PROTO_MAX_TAGS = 32;

   typedef enum logic {
      MATCH_OK     = 1'b0,
      MATCH_ORPHAN = 1'b1
   } match_kind_e;
endpackage

// File: rtl/tt_free_pool.sv
module tt_free_pool #(
   parameter int unsigned NUM_TAGS = 32,
   localparam int unsigned TAG_W = $clog2(NUM_TAGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                grant_en,
   input  logic                release_en,
   input  logic [TAG_W-1:0]    release_idx,
   output logic                any_free,
   output logic [TAG_W-1:0]    grant_idx,
   output logic [NUM_TAGS-1:0] free_vec
);
   logic [NUM_TAGS-1:0] free_q;
   logic [NUM_TAGS-1:0] free_d;

   // Lowest-index-first pick among free tags
   always_comb begin
      grant_idx = '0;
      for (int i = NUM_TAGS - 1; i >= 0; i--) begin
         if (free_q[i]) grant_idx = TAG_W'(i);
      end
   end

   assign any_free = |free_q;
   assign free_vec = free_q;

   always_comb begin
      free_d = free_q;
      if (grant_en)   free_d[grant_idx]   = 1'b0;
      if (release_en) free_d[release_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) free_q <= '1;
      else        free_q <= free_d;
   end

   // R2: the granted tag was free when granted
   assert_grant_is_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_en |-> free_q[grant_idx]);

   // R4: a granted tag is busy afterwards
   assert_grant_marks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_en |=> !free_q[$past(grant_idx)]);

   // R9: a released tag is free on the next cycle
   assert_release_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      release_en |=> free_q[$past(release_idx)]);
endmodule

// File: rtl/tt_ctx_table.sv
module tt_ctx_table #(
   parameter int unsigned NUM_TAGS = 32,
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned CMD_W    = 6,
   localparam int unsigned TAG_W = $clog2(NUM_TAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CMD_W-1:0]  wr_cmd,
   input  logic [TAG_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CMD_W-1:0]  rd_cmd
);
   logic [ADDR_W-1:0] addr_row [NUM_TAGS];
   logic [CMD_W-1:0]  cmd_row  [NUM_TAGS];

   for (genvar g = 0; g < NUM_TAGS; g++) begin : g_entry
      logic [ADDR_W-1:0] addr_q;
      logic [CMD_W-1:0]  cmd_q;
      logic              hit_w;

      assign hit_w = wr_en && (wr_idx == TAG_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
         end else if (hit_w) begin
            addr_q <= wr_addr;
            cmd_q  <= wr_cmd;
         end
      end

      assign addr_row[g] = addr_q;
      assign cmd_row[g]  = cmd_q;
   end

   assign rd_addr = addr_row[rd_idx];
   assign rd_cmd  = cmd_row[rd_idx];

   // R6: a stored context reads back on the next cycle
   assert_ctx_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_idx == wr_idx) |=> ($stable(rd_idx) -> rd_addr == $past(wr_addr)));
endmodule

// File: rtl/tt_match_stage.sv
module tt_match_stage #(
   parameter int unsigned TAG_W  = 5,
   parameter int unsigned ADDR_W = 40,
   parameter int unsigned CMD_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   input  logic              rsp_hit,
   input  logic [TAG_W-1:0]  rsp_tag,
   input  logic [ADDR_W-1:0] ctx_addr,
   input  logic [CMD_W-1:0]  ctx_cmd,
   output logic              match_valid,
   output logic              match_err,
   output logic [TAG_W-1:0]  match_tag,
   output logic [ADDR_W-1:0] match_addr,
   output logic [CMD_W-1:0]  match_cmd
);
   import tag_tracker_pkg::*;

   match_kind_e kind_d;
   assign kind_d = rsp_hit ? MATCH_OK : MATCH_ORPHAN;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_valid <= 1'b0;
         match_err   <= 1'b0;
         match_tag   <= '0;
         match_addr  <= '0;
         match_cmd   <= '0;
      end else begin
         match_valid <= rsp_valid;
         match_err   <= rsp_valid && (kind_d == MATCH_ORPHAN);
         match_tag   <= rsp_tag;
         match_addr  <= (rsp_valid && rsp_hit) ? ctx_addr : '0;
         match_cmd   <= (rsp_valid && rsp_hit) ? ctx_cmd  : '0;
      end
   end

   // R6: every response yields a result one cycle later
   assert_match_follows_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> match_valid);

   // R8: an orphan result carries no context
   assert_orphan_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match_err |-> (match_valid && match_addr == '0 && match_cmd == '0));
endmodule

// File: rtl/tag_tracker.sv
module tag_tracker #(
   parameter int unsigned NUM_TAGS = 32,
   parameter int unsigned ADDR_W   = 40,
   parameter int unsigned CMD_W    = 6,
   parameter int unsigned NODE_W   = 3,
   parameter int unsigned UNIT_W   = 2,
   localparam int unsigned TAG_W = $clog2(NUM_TAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NODE_W-1:0] node_id,
   input  logic [UNIT_W-1:0] unit_id,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CMD_W-1:0]  req_cmd,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [TAG_W-1:0]  out_tag,
   output logic [NODE_W-1:0] out_node,
   output logic [UNIT_W-1:0] out_unit,
   output logic [ADDR_W-1:0] out_addr,
   output logic [CMD_W-1:0]  out_cmd,
   input  logic              rsp_valid,
   input  logic [TAG_W-1:0]  rsp_tag,
   output logic              match_valid,
   output logic              match_err,
   output logic [TAG_W-1:0]  match_tag,
   output logic [ADDR_W-1:0] match_addr,
   output logic [CMD_W-1:0]  match_cmd
);
   import tag_tracker_pkg::*;

   if (NUM_TAGS < 2 || NUM_TAGS > PROTO_MAX_TAGS) begin : g_bad_depth
      $error("tag_tracker: NUM_TAGS must lie in 2..%0d", PROTO_MAX_TAGS);
   end
   if ((NUM_TAGS & (NUM_TAGS - 1)) != 0) begin : g_bad_pow2
      $error("tag_tracker: NUM_TAGS must be a power of two");
   end
   if (ADDR_W < 1 || CMD_W < 1 || NODE_W < 1 || UNIT_W < 1) begin : g_bad_width
      $error("tag_tracker: field widths must be nonzero");
   end

   logic                any_free;
   logic [TAG_W-1:0]    grant_idx;
   logic [NUM_TAGS-1:0] free_vec;
   logic                take;
   logic                rsp_hit;
   logic [ADDR_W-1:0]   ctx_addr;
   logic [CMD_W-1:0]    ctx_cmd;

   assign req_ready = out_ready && any_free;
   assign out_valid = req_valid && any_free;
   assign take      = req_valid && req_ready;
   assign out_tag   = grant_idx;
   assign out_node  = node_id;
   assign out_unit  = unit_id;
   assign out_addr  = req_addr;
   assign out_cmd   = req_cmd;

   assign rsp_hit = rsp_valid && !free_vec[rsp_tag];

   tt_free_pool #(.NUM_TAGS(NUM_TAGS)) u_pool (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_en    (take),
      .release_en  (rsp_hit),
      .release_idx (rsp_tag),
      .any_free    (any_free),
      .grant_idx   (grant_idx),
      .free_vec    (free_vec)
   );

   tt_ctx_table #(.NUM_TAGS(NUM_TAGS), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take),
      .wr_idx  (grant_idx),
      .wr_addr (req_addr),
      .wr_cmd  (req_cmd),
      .rd_idx  (rsp_tag),
      .rd_addr (ctx_addr),
      .rd_cmd  (ctx_cmd)
   );

   tt_match_stage #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_match (
      .clk         (clk),
      .rst_n       (rst_n),
      .rsp_valid   (rsp_valid),
      .rsp_hit     (rsp_hit),
      .rsp_tag     (rsp_tag),
      .ctx_addr    (ctx_addr),
      .ctx_cmd     (ctx_cmd),
      .match_valid (match_valid),
      .match_err   (match_err),
      .match_tag   (match_tag),
      .match_addr  (match_addr),
      .match_cmd   (match_cmd)
   );

   // R5: no request is accepted or offered while every tag is busy
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (free_vec == '0) |-> (!req_ready && !out_valid));

   // R8: an orphan response with no grant leaves the pool unchanged
   assert_orphan_keeps_pool_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && !take) |=> $stable(free_vec));

   // R10: grant and release in one cycle both land
   assert_grant_and_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rsp_hit) |=> (!free_vec[$past(grant_idx)] && free_vec[$past(rsp_tag)]));
endmodule

// File: tb/test_tag_tracker.sv
module test_tag_tracker;
   localparam int N  = 32;
   localparam int TW = 5;
   localparam int AW = 40;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    node_id = 3'd5;
   logic [1:0]    unit_id = 2'd2;
   logic          req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_cmd = '0;
   logic          out_valid, out_ready = 1'b1;
   logic [TW-1:0] out_tag;
   logic [2:0]    out_node;
   logic [1:0]    out_unit;
   logic [AW-1:0] out_addr;
   logic [CW-1:0] out_cmd;
   logic          rsp_valid = 1'b0;
   logic [TW-1:0] rsp_tag = '0;
   logic          match_valid, match_err;
   logic [TW-1:0] match_tag;
   logic [AW-1:0] match_addr;
   logic [CW-1:0] match_cmd;

   int n_run = 0, n_fail = 0;
   bit busy [N];
   logic [AW-1:0] m_addr [N];
   logic [CW-1:0] m_cmd  [N];

   always #10 clk = ~clk;

   tag_tracker i_tag_tracker (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < N; i++) if (!busy[i]) return i;
      return -1;
   endfunction

   // One cycle: optional request and optional response, checked at their due times
   task automatic step(input bit do_req, input logic [AW-1:0] a, input logic [CW-1:0] c,
                       input bit do_rsp, input int rt, input string tagname);
      int exp_tag;
      bit exp_hit;
      @(negedge clk);
      req_valid = do_req; req_addr = a; req_cmd = c;
      rsp_valid = do_rsp; rsp_tag = TW'(rt);
      #1;
      exp_tag = lowest_free();
      exp_hit = do_rsp && busy[rt];
      if (do_req && exp_tag >= 0) begin
         chk(out_valid == 1'b1, {tagname, " R4 out_valid"}, out_valid, 1);
         chk(out_tag == TW'(exp_tag), {tagname, " R2 out_tag"}, out_tag, exp_tag);
         chk(out_node == node_id && out_unit == unit_id, {tagname, " R3 node/unit"},
             {out_node, out_unit}, {node_id, unit_id});
         chk(out_addr == a && out_cmd == c, {tagname, " R3 addr/cmd"}, out_addr, a);
      end
      @(posedge clk);
      if (do_req && exp_tag >= 0 && out_ready) begin
         busy[exp_tag] = 1'b1; m_addr[exp_tag] = a; m_cmd[exp_tag] = c;
      end
      #1;
      if (do_rsp) begin
         chk(match_valid == 1'b1, {tagname, " R6 match_valid"}, match_valid, 1);
         chk(match_tag == TW'(rt), {tagname, " R6 match_tag"}, match_tag, rt);
         if (exp_hit) begin
            chk(match_err == 1'b0, {tagname, " R7 match_err"}, match_err, 0);
            chk(match_addr == m_addr[rt] && match_cmd == m_cmd[rt], {tagname, " R7 context"},
                match_addr, m_addr[rt]);
            busy[rt] = 1'b0;
         end else begin
            chk(match_err == 1'b1, {tagname, " R8 match_err"}, match_err, 1);
            chk(match_addr == '0 && match_cmd == '0, {tagname, " R8 empty context"}, match_addr, 0);
         end
      end
      req_valid = 1'b0; rsp_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
      chk(match_valid == 1'b0, "R1 match_valid", match_valid, 0);
      chk(out_tag == '0, "R1 first tag", out_tag, 0);
   endtask

   task automatic t_basic_ooo();
      step(1, 40'h10_0000_0040, 6'h04, 0, 0, "basic0");
      step(1, 40'h10_0000_0080, 6'h05, 0, 0, "basic1");
      step(1, 40'h10_0000_00C0, 6'h06, 0, 0, "basic2");
      step(0, '0, '0, 1, 1, "ooo1");
      step(0, '0, '0, 1, 2, "ooo2");
      step(0, '0, '0, 1, 0, "ooo0");
   endtask

   task automatic t_backpressure();
      @(negedge clk);
      out_ready = 1'b0; req_valid = 1'b1; req_addr = 40'hAB; req_cmd = 6'h3;
      #1;
      chk(req_ready == 1'b0, "R4 ready low under backpressure", req_ready, 0);
      chk(out_valid == 1'b1, "R4 valid under backpressure", out_valid, 1);
      chk(out_tag == '0, "R4 tag before stall", out_tag, 0);
      @(posedge clk); #1;
      @(negedge clk); #1;
      chk(out_tag == '0, "R4 tag held after stall", out_tag, 0);
      req_valid = 1'b0; out_ready = 1'b1;
   endtask

   task automatic t_orphan();
      step(0, '0, '0, 1, 9, "orphan9");
      @(negedge clk); #1;
      chk(out_tag == TW'(lowest_free()), "R8 pool unchanged", out_tag, lowest_free());
   endtask

   task automatic t_fill_and_reuse();
      for (int i = 0; i < N; i++) step(1, AW'(64'h2000 + i * 64), CW'(i), 0, 0, "fill");
      @(negedge clk); req_valid = 1'b1; #1;
      chk(req_ready == 1'b0, "R5 req_ready when full", req_ready, 0);
      chk(out_valid == 1'b0, "R5 out_valid when full", out_valid, 0);
      req_valid = 1'b0;
      step(0, '0, '0, 1, 17, "free17");
      @(negedge clk); #1;
      chk(req_ready == 1'b1, "R9 ready after release", req_ready, 1);
      chk(out_tag == 5'd17, "R9 released tag granted next", out_tag, 17);
      step(1, 40'h77_0000, 6'h2A, 0, 0, "regrant17");
      step(0, '0, '0, 1, 3, "free3");
      // R10: grant tag 3 while releasing tag 10 in the same cycle
      step(1, 40'h88_0000, 6'h15, 1, 10, "simul");
      @(negedge clk); #1;
      chk(out_tag == 5'd10, "R10 released tag now lowest", out_tag, 10);
      for (int i = N - 1; i >= 0; i--) if (busy[i]) step(0, '0, '0, 1, i, "drain");
      @(negedge clk); #1;
      chk(out_tag == '0 && req_ready, "R7 all tags back", out_tag, 0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) busy[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic_ooo();
      t_backpressure();
      t_orphan();
      t_fill_and_reuse();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule